// File: doc/BRIEF.md
# Iterative Lightweight Feistel Block Cipher

This core encrypts or decrypts one block of `N` bits under an `N`-bit key. It runs one Feistel round per clock and derives each round key in the same cycle, so no key table is stored. The data path splits each half-block into `NB = N/(2W)` words of `W` bits. Each round mixes the right half with a round key. The mix is a word-wise modular addition, then a 3-bit substitution taken across word triples, then a fixed per-word bit rotation. A word rotation on the left half is the only part that differs between the two directions.

A one-cycle or held `start` loads the text, the key and the direction. After `NR` rounds, `done` pulses once, and `result` holds the finished block until the next load. Any `start` seen while rounds are in progress is dropped. `N` must be a multiple of `6W`. `NR` is odd. By default, `NR` is computed from `N` and `W`, and it can be overridden.

Top module: `sfc_core`

## Requirements
- R1: When the core is idle, a high `start` at a clock edge loads `text_in[N-1:N/2]` as the left half L and `text_in[N/2-1:0]` as the right half R. In the same way it loads `key_in` as KL (upper) and KR (lower), and it latches `encrypt` (1 = encrypt, 0 = decrypt). Word i of any half occupies bits `[i*W +: W]`.
- R2: The substitution maps 3-bit values 0..7 to 0,5,6,7,4,3,1,2. For each bit position it takes one bit from each word of a triple (3t, 3t+1, 3t+2). Word 3t supplies the least significant bit.
- R3: The round mix adds the right half and the round key word by word, modulo 2^W, with no carry between words. Rounds 1..H use KR as the round key and later rounds use KL, where H = (NR+1)/2.
- R4: The bit rotation turns word 3t right by one bit and word 3t+2 left by one bit, and leaves word 3t+1 unchanged.
- R5: The encrypt round sets new L = R. It sets new R = WR(L) xor F, where WR moves word i to position (i+1) mod NB and F is the rotated substitution of the mix.
- R6: The decrypt round sets new L = R. It sets new R = IWR(L xor F), where IWR moves word (i+1) mod NB to position i.
- R7: The key state updates alongside round j. For j < H it sets KL' = KR and KR' = KL xor WR(F(KR, C)) with C = j. At j = H it only swaps KL and KR. For j > H it uses the same step with C = NR − j. C is zero-extended across the words, least significant word first.
- R8: `done` is high for exactly one cycle, NR clock edges after the loading edge. `result` = {R, L} of the final state.
- R9: A `start` that arrives while rounds are running has no effect on the operation in progress or on its result.
- R10: Reset clears `done` and the state, so `result` reads zero. While idle with no `start`, `result` does not change.
- R11: The default round count is (3N/4 + 2·(NB + ⌊W/2⌋)) with bit 0 forced to one, which is 53 for N = 48 and W = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load request, honoured only when idle |
| encrypt | input | 1 | 1 selects encryption, 0 decryption |
| text_in | input | N | Plaintext or ciphertext block |
| key_in | input | N | Cipher key |
| result | output | N | {R, L} of the current state; valid from `done` until the next load |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the control timing on every cycle. It checks that `done` is a single pulse, that it comes exactly NR running cycles after a load, that an idle `start` always begins a run, and that `result` holds while idle. The round arithmetic cannot be seen by a property: the substitution, the two word rotations, the carry-free addition, the key-half switch and the round constants. The bench checks these by running a behavioural model of the rounds in lockstep with the core, over several encrypt and decrypt patterns, including a `start` pulse during a run and a `start` held high across completions.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sfc_state_e;

    typedef struct packed {
        logic load;
        logic run;
        logic use_kr;
        logic key_swap;
    } sfc_ctrl_t;

    function automatic logic [2:0] sfc_sbox(input logic [2:0] v);
        logic [2:0] o;
        case (v)
            3'd0:    o = 3'd0;
            3'd1:    o = 3'd5;
            3'd2:    o = 3'd6;
            3'd3:    o = 3'd7;
            3'd4:    o = 3'd4;
            3'd5:    o = 3'd3;
            3'd6:    o = 3'd1;
            default: o = 3'd2;
        endcase
        return o;
    endfunction

    function automatic int sfc_default_rounds(input int n, input int b);
        return (3 * n / 4 + 2 * (n / (2 * b) + b / 2)) | 1;
    endfunction

endpackage

// File: rtl/sfc_mix.sv
module sfc_mix #(
    parameter int NB = 6,
    parameter int WB = 4
) (
    input  logic [NB*WB-1:0] x_i,
    input  logic [NB*WB-1:0] k_i,
    output logic [NB*WB-1:0] y_o
);
    import sfc_pkg::*;

    localparam int HB = NB * WB;
    localparam int NT = NB / 3;

    logic [HB-1:0] sum;
    logic [HB-1:0] sub;

    // word-wise addition, carries stay inside each word
    for (genvar w = 0; w < NB; w++) begin : g_add
        assign sum[w*WB +: WB] = x_i[w*WB +: WB] + k_i[w*WB +: WB];
    end

    // bit-sliced substitution over each word triple
    for (genvar t = 0; t < NT; t++) begin : g_tri
        for (genvar bt = 0; bt < WB; bt++) begin : g_bit
            logic [2:0] so;
            assign so = sfc_sbox({sum[(3*t+2)*WB+bt], sum[(3*t+1)*WB+bt], sum[3*t*WB+bt]});
            assign sub[3*t*WB+bt]     = so[0];
            assign sub[(3*t+1)*WB+bt] = so[1];
            assign sub[(3*t+2)*WB+bt] = so[2];
        end

        logic [WB-1:0] w_lo, w_hi;
        assign w_lo = sub[3*t*WB +: WB];
        assign w_hi = sub[(3*t+2)*WB +: WB];
        assign y_o[3*t*WB +: WB]     = {w_lo[0], w_lo[WB-1:1]};
        assign y_o[(3*t+1)*WB +: WB] = sub[(3*t+1)*WB +: WB];
        assign y_o[(3*t+2)*WB +: WB] = {w_hi[WB-2:0], w_hi[WB-1]};
    end

endmodule

// File: rtl/sfc_round.sv
module sfc_round #(
    parameter int NB = 6,
    parameter int WB = 4
) (
    input  logic [NB*WB-1:0] l_i,
    input  logic [NB*WB-1:0] r_i,
    input  logic [NB*WB-1:0] k_i,
    input  logic             enc_i,
    output logic [NB*WB-1:0] l_o,
    output logic [NB*WB-1:0] r_o
);
    localparam int HB = NB * WB;

    logic [HB-1:0] f;
    logic [HB-1:0] wrot;
    logic [HB-1:0] xdec;
    logic [HB-1:0] iwrot;

    sfc_mix #(.NB(NB), .WB(WB)) u_mix (
        .x_i (r_i),
        .k_i (k_i),
        .y_o (f)
    );

    assign xdec = l_i ^ f;

    for (genvar w = 0; w < NB; w++) begin : g_rot
        assign wrot[((w+1)%NB)*WB +: WB] = l_i[w*WB +: WB];
        assign iwrot[w*WB +: WB]         = xdec[((w+1)%NB)*WB +: WB];
    end

    assign l_o = r_i;
    assign r_o = enc_i ? (wrot ^ f) : iwrot;

endmodule

// File: rtl/sfc_keysched.sv
module sfc_keysched #(
    parameter int NB = 6,
    parameter int WB = 4,
    parameter int CW = 6
) (
    input  logic [NB*WB-1:0] kl_i,
    input  logic [NB*WB-1:0] kr_i,
    input  logic [CW-1:0]    cst_i,
    input  logic             swap_i,
    output logic [NB*WB-1:0] kl_o,
    output logic [NB*WB-1:0] kr_o
);
    localparam int HB = NB * WB;

    logic [HB-1:0] cvec;
    logic [HB-1:0] g;
    logic [HB-1:0] grot;

    if (CW >= HB) begin : g_ctrunc
        assign cvec = cst_i[HB-1:0];
    end else begin : g_cext
        assign cvec = {{(HB-CW){1'b0}}, cst_i};
    end

    sfc_mix #(.NB(NB), .WB(WB)) u_mix (
        .x_i (kr_i),
        .k_i (cvec),
        .y_o (g)
    );

    for (genvar w = 0; w < NB; w++) begin : g_rot
        assign grot[((w+1)%NB)*WB +: WB] = g[w*WB +: WB];
    end

    assign kl_o = kr_i;
    assign kr_o = swap_i ? kl_i : (kl_i ^ grot);

endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl #(
    parameter int NR = 53,
    parameter int CW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    output sfc_pkg::sfc_ctrl_t  ctl_o,
    output logic [CW-1:0]       cst_o,
    output logic                done_o
);
    import sfc_pkg::*;

    localparam int HALF = (NR + 1) / 2;

    sfc_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CW'(1);
                    end
                end
                default: begin
                    if (cnt_q == CW'(NR)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        ctl_o.load     = (state_q == ST_IDLE) && start_i;
        ctl_o.run      = (state_q == ST_RUN);
        ctl_o.use_kr   = (cnt_q <= CW'(HALF));
        ctl_o.key_swap = (cnt_q == CW'(HALF));
        cst_o          = (cnt_q < CW'(HALF)) ? cnt_q : (CW'(NR) - cnt_q);
    end

    assign done_o = done_q;

endmodule

// File: rtl/sfc_core.sv
module sfc_core #(
    parameter int N  = 48,
    parameter int W  = 4,
    parameter int NR = sfc_pkg::sfc_default_rounds(N, W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         encrypt,
    input  logic [N-1:0] text_in,
    input  logic [N-1:0] key_in,
    output logic [N-1:0] result,
    output logic         done
);
    import sfc_pkg::*;

    localparam int NB = N / (2 * W);
    localparam int HB = N / 2;
    localparam int CW = $clog2(NR + 1);

    sfc_ctrl_t     ctl;
    logic [CW-1:0] cst;
    logic          busy;

    logic [HB-1:0] l_q, r_q, kl_q, kr_q;
    logic          enc_q;
    logic [HB-1:0] l_n, r_n, kl_n, kr_n, rkey;

    sfc_ctrl #(.NR(NR), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .ctl_o   (ctl),
        .cst_o   (cst),
        .done_o  (done)
    );

    assign rkey = ctl.use_kr ? kr_q : kl_q;

    sfc_round #(.NB(NB), .WB(W)) u_round (
        .l_i   (l_q),
        .r_i   (r_q),
        .k_i   (rkey),
        .enc_i (enc_q),
        .l_o   (l_n),
        .r_o   (r_n)
    );

    sfc_keysched #(.NB(NB), .WB(W), .CW(CW)) u_key (
        .kl_i   (kl_q),
        .kr_i   (kr_q),
        .cst_i  (cst),
        .swap_i (ctl.key_swap),
        .kl_o   (kl_n),
        .kr_o   (kr_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q   <= '0;
            r_q   <= '0;
            kl_q  <= '0;
            kr_q  <= '0;
            enc_q <= 1'b0;
        end else if (ctl.load) begin
            l_q   <= text_in[N-1:HB];
            r_q   <= text_in[HB-1:0];
            kl_q  <= key_in[N-1:HB];
            kr_q  <= key_in[HB-1:0];
            enc_q <= encrypt;
        end else if (ctl.run) begin
            l_q  <= l_n;
            r_q  <= r_n;
            kl_q <= kl_n;
            kr_q <= kr_n;
        end
    end

    assign busy   = ctl.run;
    assign result = {r_q, l_q};

endmodule

// File: rtl/sfc_core_chk.sv
module sfc_core_chk #(
    parameter int N  = 48,
    parameter int NR = 53
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic         busy,
    input logic [N-1:0] result
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            run_cnt <= '0;
        else if (start && !busy)
            run_cnt <= '0;
        else if (busy)
            run_cnt <= run_cnt + 16'd1;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R8
    round_count_chk: assert property (@(posedge clk) disable iff (rst) done |-> (run_cnt == 16'(NR)));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R1
    start_run_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(result));

    // R10
    reset_state_chk: assert property (@(posedge clk) rst |=> (!busy && !done && (result == '0)));

endmodule

bind sfc_core sfc_core_chk #(.N(N), .NR(NR)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .result (result)
);

// File: tb/sfc_core_tb_top.sv
`timescale 1ns/1ps
module sfc_core_tb_top;

    localparam int N      = 48;
    localparam int W      = 4;
    localparam int NB     = 6;
    localparam int NR_EXP = 53;           // R11: 36 + 2*(6+2) = 52, bit0 forced -> 53
    localparam int HALF   = (NR_EXP + 1) / 2;
    localparam int MSK    = 15;

    typedef int unsigned wv_t [NB];

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         encrypt = 1'b1;
    logic [N-1:0] text_in = '0;
    logic [N-1:0] key_in = '0;
    logic [N-1:0] result;
    logic         done;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R10";
    bit finished = 0;

    always #2 clk = ~clk;

    sfc_core #(.N(N), .W(W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .encrypt (encrypt),
        .text_in (text_in),
        .key_in  (key_in),
        .result  (result),
        .done    (done)
    );

    // ---------------- behavioural reference ----------------
    wv_t ml, mr, mkl, mkr;
    bit  m_busy = 0, m_done = 0, m_enc = 0, m_live = 0;
    int  m_cnt = 0;
    logic [N-1:0] m_res = '0;

    function automatic int unsigned sb(input int unsigned v);
        int unsigned tbl [8] = '{0, 5, 6, 7, 4, 3, 1, 2};   // R2
        return tbl[v];
    endfunction

    task automatic mixf(input wv_t x, input wv_t k, output wv_t y);
        wv_t s, z;
        for (int i = 0; i < NB; i++) begin
            s[i] = (x[i] + k[i]) & MSK;                      // R3
            z[i] = 0;
        end
        for (int t = 0; t < NB / 3; t++) begin
            for (int b = 0; b < W; b++) begin
                int unsigned v, o;
                v = ((s[3*t] >> b) & 1) | (((s[3*t+1] >> b) & 1) << 1) | (((s[3*t+2] >> b) & 1) << 2);
                o = sb(v);
                z[3*t]   |= (o & 1) << b;
                z[3*t+1] |= ((o >> 1) & 1) << b;
                z[3*t+2] |= ((o >> 2) & 1) << b;
            end
        end
        for (int t = 0; t < NB / 3; t++) begin                // R4
            y[3*t]   = ((z[3*t] >> 1) | (z[3*t] << (W - 1))) & MSK;
            y[3*t+1] = z[3*t+1];
            y[3*t+2] = ((z[3*t+2] << 1) | (z[3*t+2] >> (W - 1))) & MSK;
        end
    endtask

    task automatic unpack_half(input logic [N/2-1:0] v, output wv_t w);
        for (int i = 0; i < NB; i++) w[i] = (v >> (i * W)) & MSK;
    endtask

    function automatic logic [N/2-1:0] pack_half(input wv_t w);
        logic [N/2-1:0] v = '0;
        for (int i = 0; i < NB; i++) v = v | ((N/2)'(w[i]) << (i * W));
        return v;
    endfunction

    task automatic model_round();
        wv_t k, f, nr_, cw, g, nkl, nkr, tx;
        int  c;
        k = (m_cnt <= HALF) ? mkr : mkl;                      // R3
        mixf(mr, k, f);
        if (m_enc) begin                                      // R5
            for (int i = 0; i < NB; i++) nr_[(i + 1) % NB] = ml[i] ^ f[(i + 1) % NB];
        end else begin                                        // R6
            for (int i = 0; i < NB; i++) tx[i] = ml[i] ^ f[i];
            for (int i = 0; i < NB; i++) nr_[i] = tx[(i + 1) % NB];
        end
        if (m_cnt == HALF) begin                              // R7
            nkl = mkr;
            nkr = mkl;
        end else begin
            c = (m_cnt < HALF) ? m_cnt : (NR_EXP - m_cnt);
            for (int i = 0; i < NB; i++) cw[i] = (c >> (i * W)) & MSK;
            mixf(mkr, cw, g);
            nkl = mkr;
            for (int i = 0; i < NB; i++) nkr[(i + 1) % NB] = mkl[(i + 1) % NB] ^ g[i];
        end
        ml  = mr;
        mr  = nr_;
        mkl = nkl;
        mkr = nkr;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            for (int i = 0; i < NB; i++) begin ml[i] = 0; mr[i] = 0; mkl[i] = 0; mkr[i] = 0; end
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin                              // R1
                    unpack_half(text_in[N-1:N/2], ml);
                    unpack_half(text_in[N/2-1:0], mr);
                    unpack_half(key_in[N-1:N/2], mkl);
                    unpack_half(key_in[N/2-1:0], mkr);
                    m_enc  = encrypt;
                    m_cnt  = 1;
                    m_busy = 1;
                end
            end else begin
                model_round();
                if (m_cnt == NR_EXP) begin                    // R8
                    m_busy = 0;
                    m_done = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
        m_res  = {pack_half(mr), pack_half(ml)};
        m_live = 1;
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (m_live && !finished) begin
            n_chk++;
            if (done !== m_done) begin
                n_fail++;
                $display("FAIL R8 R11 done: actual %0b expected %0b at %0t", done, m_done, $time);
            end
            n_chk++;
            if (result !== m_res) begin
                n_fail++;
                $display("FAIL %s result: actual %h expected %h at %0t",
                         (m_busy || m_done) ? cur_tag : "R10", result, m_res, $time);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done();
        do @(negedge clk); while (!m_done);
    endtask

    task automatic run_op(input bit enc, input logic [N-1:0] t, input logic [N-1:0] k, input string tag);
        @(negedge clk);
        cur_tag = tag;
        encrypt = enc; text_in = t; key_in = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic finish_up();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        n_chk++;
        if (done !== 1'b0 || result !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: actual done=%0b result=%h expected 0/0", done, result);
        end
        rst = 1'b0;
        repeat (4) @(negedge clk);

        run_op(1'b1, 48'h0, 48'h0, "R5 R2 R7");                          // all-zero encrypt
        run_op(1'b1, 48'h0123_4567_89AB, 48'hFEDC_BA98_7654, "R5 R3 R4");
        run_op(1'b1, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, "R5 R3");   // carries wrap inside words
        run_op(1'b1, 48'h8000_0000_0001, 48'h0000_0000_0000, "R5 R4");
        run_op(1'b0, 48'h0, 48'h0, "R6 R7");
        run_op(1'b0, 48'hA5A5_5A5A_C3C3, 48'h1357_9BDF_2468, "R6 R2");
        run_op(1'b0, 48'h7777_0000_7777, 48'h0F0F_F0F0_0F0F, "R6 R3");

        // R9: start pulse during a run with different data
        @(negedge clk);
        cur_tag = "R9";
        encrypt = 1'b1; text_in = 48'h1111_2222_3333; key_in = 48'h4444_5555_6666; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        encrypt = 1'b0; text_in = 48'hDEAD_BEEF_0000; key_in = 48'h0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();

        // R1 R9: start held high across completions, back-to-back loads
        @(negedge clk);
        cur_tag = "R1 R9";
        encrypt = 1'b0; text_in = 48'h0F1E_2D3C_4B5A; key_in = 48'h9988_7766_5544; start = 1'b1;
        wait_done();
        text_in = 48'h6978_8796_A5B4;
        wait_done();
        start = 1'b0;

        // R10: idle hold
        cur_tag = "R10";
        repeat (20) @(negedge clk);
        finish_up();
    end

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule